// File: doc/BRIEF.md
# I2C Master Service-Status Register

This block keeps the software-visible status of an I2C master engine. The bus engine sends one-cycle event strobes. These report an address acknowledged for read or for write, a NACK on the address, a NACK on data, lost arbitration, a completed transfer and an idle bus. From these strobes the block keeps three things. The first is a pending flag that tells software the master waits for service or is idle. The second is a 3-bit code that says which service is needed. The third is a sticky flag that records lost arbitration.

Software uses a two-word register port. Word 0 is the status word. It returns the pending flag, the code and the arbitration flag, and the arbitration flag clears when 1 is written to it. Word 1 is the control word. It holds two command strobes, continue and start, and two stored bits, DMA mode and interrupt enable. A level interrupt is raised while pending is set and the interrupt is enabled. In DMA mode a DMA engine handles the read-ready and write-ready events, so those events do not raise pending.

Top module: `i2c_mst_status`

## Requirements
- R1: After a synchronous active-low reset, the status word reads 0x01: pending (bit 0) is 1, the code (bits 3:1) is 0 and the arbitration flag (bit 4) is 0. The control word reads 0 and irq is 0.
- R2: With DMA mode off, an address-acknowledged-for-read strobe makes the status word read pending=1 and code=1 (0x03) on the next cycle.
- R3: With DMA mode off, an address-acknowledged-for-write strobe gives pending=1 and code=2 (0x05) on the next cycle.
- R4: An address NACK strobe gives pending=1 and code=3 (0x07). A data NACK strobe gives pending=1 and code=4 (0x09). Both apply in either DMA mode.
- R5: An arbitration-lost strobe gives pending=1, code=0 and arbitration flag=1 (0x11).
- R6: A transfer-done strobe or a bus-idle strobe gives pending=1 and code=0.
- R7: With DMA mode on (control bit 2), the read-ready and write-ready strobes update the code but leave pending unchanged.
- R8: Writing the control word with bit 0 (continue) or bit 1 (start) set clears pending on the next cycle and leaves the code unchanged. If an event strobe arrives in the same cycle, the event wins.
- R9: The arbitration flag is sticky. Writing 1 to status bit 4 clears it, and so does a continue command. Writing 0 to bit 4 has no effect. A new arbitration-lost strobe in the same cycle as a clear keeps the flag set.
- R10: irq is 1 exactly while pending is 1 and interrupt enable (control bit 3) is 1.
- R11: Status bits 3:0 are read-only. Read bits above the defined fields return 0. Control bits 0 and 1 always read 0. The code never takes the values 5 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_ack_rd | input | 1 | Address acknowledged, read direction |
| ev_ack_wr | input | 1 | Address acknowledged, write direction |
| ev_nack_addr | input | 1 | Slave did not acknowledge address |
| ev_nack_data | input | 1 | Slave did not acknowledge data |
| ev_arb_lost | input | 1 | Arbitration lost, bus released |
| ev_done | input | 1 | Transfer finished with stop |
| ev_idle | input | 1 | Bus found idle |
| addr | input | 1 | Register select: 0 status, 1 control |
| wr_en | input | 1 | Write strobe |
| wdata | input | 5 | Write data |
| rdata | output | DW | Read data for the selected word |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume the bus engine raises at most one event strobe per cycle. The mapping assertions only apply when exactly one strobe is high, because the block resolves several strobes by a fixed priority that no requirement states. The stimulus raises a single strobe at a time. The one exception is a strobe paired with a register write in the same cycle, which tests the cases where the event must win over a clear. The reference model in the bench is compared with the design on every clock.

// File: rtl/i2c_mst_status.sv
module i2c_mst_status #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_ack_rd,
  input  logic          ev_ack_wr,
  input  logic          ev_nack_addr,
  input  logic          ev_nack_data,
  input  logic          ev_arb_lost,
  input  logic          ev_done,
  input  logic          ev_idle,
  input  logic          addr,
  input  logic          wr_en,
  input  logic [4:0]    wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int CW = 3;
  localparam logic [CW-1:0] C_IDLE = 3'd0, C_RXRDY = 3'd1, C_TXRDY = 3'd2,
                            C_NADDR = 3'd3, C_NDATA = 3'd4;

  logic          pend_q, arb_q, dma_q, ien_q;
  logic [CW-1:0] code_q;
  logic          ev_any, ev_pend;
  logic [CW-1:0] ev_code;

  wire wr_stat  = wr_en & ~addr;
  wire wr_ctl   = wr_en & addr;
  wire cont_cmd = wr_ctl & wdata[0];
  wire cmd      = wr_ctl & (wdata[0] | wdata[1]);
  wire arb_clr  = (wr_stat & wdata[4]) | cont_cmd;

  assign ev_any = ev_ack_rd | ev_ack_wr | ev_nack_addr | ev_nack_data |
                  ev_arb_lost | ev_done | ev_idle;

  always_comb begin
    ev_pend = 1'b1;
    ev_code = C_IDLE;
    if (ev_arb_lost)       ev_code = C_IDLE;
    else if (ev_nack_addr) ev_code = C_NADDR;
    else if (ev_nack_data) ev_code = C_NDATA;
    else if (ev_ack_rd)    begin ev_code = C_RXRDY; ev_pend = ~dma_q; end
    else if (ev_ack_wr)    begin ev_code = C_TXRDY; ev_pend = ~dma_q; end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b1;
      code_q <= C_IDLE;
      arb_q  <= 1'b0;
      dma_q  <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      if (ev_any && ev_pend) pend_q <= 1'b1;
      else if (cmd)          pend_q <= 1'b0;
      if (ev_any) code_q <= ev_code;
      if (ev_arb_lost)  arb_q <= 1'b1;
      else if (arb_clr) arb_q <= 1'b0;
      if (wr_ctl) begin
        dma_q <= wdata[2];
        ien_q <= wdata[3];
      end
    end
  end

  assign rdata = addr ? DW'({ien_q, dma_q, 2'b00})
                      : DW'({arb_q, code_q, pend_q});
  assign irq = pend_q & ien_q;
endmodule

module i2c_mst_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] evs,
  input logic       wr_en,
  input logic       addr,
  input logic [4:0] wdata,
  input logic       pend_q,
  input logic [2:0] code_q,
  input logic       arb_q,
  input logic       dma_q
);
  wire one   = $countones(evs) == 1;
  wire none  = evs == 7'd0;
  wire wctl  = wr_en & addr;
  wire wstat = wr_en & ~addr;
  wire cmd   = wctl & (wdata[0] | wdata[1]);

  a_r2_rx_ready: assert property (@(posedge clk) disable iff (!rst_n)
    one && evs[0] && !dma_q |=> pend_q && code_q == 3'd1);
  a_r3_tx_ready: assert property (@(posedge clk) disable iff (!rst_n)
    one && evs[1] && !dma_q |=> pend_q && code_q == 3'd2);
  a_r4_nack_addr: assert property (@(posedge clk) disable iff (!rst_n)
    one && evs[2] |=> pend_q && code_q == 3'd3);
  a_r4_nack_data: assert property (@(posedge clk) disable iff (!rst_n)
    one && evs[3] |=> pend_q && code_q == 3'd4);
  a_r5_arb_lost: assert property (@(posedge clk) disable iff (!rst_n)
    evs[4] |=> arb_q && pend_q && code_q == 3'd0);
  a_r6_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    one && (evs[5] || evs[6]) |=> pend_q && code_q == 3'd0);
  a_r7_dma_hold: assert property (@(posedge clk) disable iff (!rst_n)
    one && (evs[0] || evs[1]) && dma_q && !cmd |=> $stable(pend_q));
  a_r8_cmd_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cmd && none |=> !pend_q && $stable(code_q));
  a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    wstat && wdata[4] && !evs[4] |=> !arb_q);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    arb_q && !(wstat && wdata[4]) && !(wctl && wdata[0]) |=> arb_q);
  a_r11_ro_status: assert property (@(posedge clk) disable iff (!rst_n)
    wstat && none |=> $stable(code_q) && $stable(pend_q));
  a_r11_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    code_q <= 3'd4);
endmodule

bind i2c_mst_status i2c_mst_status_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .evs({ev_idle, ev_done, ev_arb_lost, ev_nack_data, ev_nack_addr, ev_ack_wr, ev_ack_rd}),
  .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .pend_q(pend_q), .code_q(code_q), .arb_q(arb_q), .dma_q(dma_q)
);

// File: tb/i2c_mst_status_tb.sv
`timescale 1ns/1ps
module i2c_mst_status_tb;
  localparam int DW = 32;
  logic clk = 0, rst_n = 0;
  logic [6:0] ev = '0;
  logic addr = 0, wr_en = 0;
  logic [4:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit model_on = 0;

  always #2.5 clk = ~clk;

  i2c_mst_status #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ev_ack_rd(ev[0]), .ev_ack_wr(ev[1]), .ev_nack_addr(ev[2]), .ev_nack_data(ev[3]),
    .ev_arb_lost(ev[4]), .ev_done(ev[5]), .ev_idle(ev[6]),
    .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  int m_pend, m_code, m_arb, m_dma, m_ien;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend <= 1; m_code <= 0; m_arb <= 0; m_dma <= 0; m_ien <= 0;
    end else begin
      int np, nc, na;
      np = m_pend; nc = m_code; na = m_arb;
      if (wr_en && addr && (wdata[0] || wdata[1])) np = 0;
      if ((wr_en && !addr && wdata[4]) || (wr_en && addr && wdata[0])) na = 0;
      if (ev[4]) begin nc = 0; np = 1; na = 1; end
      else if (ev[2]) begin nc = 3; np = 1; end
      else if (ev[3]) begin nc = 4; np = 1; end
      else if (ev[0]) begin nc = 1; if (m_dma == 0) np = 1; end
      else if (ev[1]) begin nc = 2; if (m_dma == 0) np = 1; end
      else if (ev[5] || ev[6]) begin nc = 0; np = 1; end
      m_pend <= np; m_code <= nc; m_arb <= na;
      if (wr_en && addr) begin m_dma <= wdata[2]; m_ien <= wdata[3]; end
    end
  end

  always @(posedge clk) begin
    #1;
    if (model_on) begin
      int exp_rd, exp_irq;
      exp_rd  = addr ? (m_ien * 8 + m_dma * 4) : (m_arb * 16 + m_code * 2 + m_pend);
      exp_irq = (m_pend != 0 && m_ien != 0) ? 1 : 0;
      checks++;
      if (rdata !== DW'(exp_rd) || irq !== exp_irq[0]) begin
        errors++;
        $display("FAIL model R10/R11: rdata=%h irq=%b expected rdata=%h irq=%b",
                 rdata, irq, exp_rd, exp_irq[0]);
      end
    end
  end

  task automatic cyc(input logic [6:0] e, input logic w, input logic a, input logic [4:0] d);
    @(negedge clk);
    ev = e; wr_en = w; addr = a; wdata = d;
    @(negedge clk);
    ev = '0; wr_en = 0; wdata = '0;
  endtask

  task automatic pulse(input int idx);
    cyc(7'(1 << idx), 1'b0, 1'b0, 5'd0);
  endtask

  task automatic chk(input string tag, input logic a, input logic [DW-1:0] exp_rd, input logic exp_irq);
    addr = a;
    #0.5;
    checks++;
    if (rdata !== exp_rd || irq !== exp_irq) begin
      errors++;
      $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b", tag, rdata, irq, exp_rd, exp_irq);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    model_on = 1;
    chk("R1 status", 0, 32'h01, 0);
    chk("R1 control", 1, 32'h00, 0);
    cyc('0, 1, 1, 5'h08);            chk("R10 irq on", 0, 32'h01, 1);
    cyc('0, 1, 1, 5'h0A);            chk("R8 start", 0, 32'h00, 0);
    pulse(0);                        chk("R2 rx ready", 0, 32'h03, 1);
    cyc('0, 1, 1, 5'h09);            chk("R8 continue", 0, 32'h02, 0);
    pulse(1);                        chk("R3 tx ready", 0, 32'h05, 1);
    cyc('0, 1, 1, 5'h09);            chk("R8 continue", 0, 32'h04, 0);
    pulse(3);                        chk("R4 nack data", 0, 32'h09, 1);
    cyc('0, 1, 1, 5'h09);
    pulse(2);                        chk("R4 nack addr", 0, 32'h07, 1);
    pulse(5);                        chk("R6 done", 0, 32'h01, 1);
    cyc('0, 1, 1, 5'h0A);
    pulse(6);                        chk("R6 idle", 0, 32'h01, 1);
    cyc('0, 1, 1, 5'h0A);
    pulse(4);                        chk("R5 arb lost", 0, 32'h11, 1);
    cyc('0, 1, 0, 5'h00);            chk("R9 write zero", 0, 32'h11, 1);
    cyc('0, 1, 0, 5'h10);            chk("R9 w1c", 0, 32'h01, 1);
    pulse(4);
    cyc('0, 1, 1, 5'h09);            chk("R9 continue clears", 0, 32'h00, 0);
    pulse(4);
    cyc(7'h10, 1, 0, 5'h10);         chk("R9 event beats clear", 0, 32'h11, 1);
    cyc('0, 1, 0, 5'h10);
    cyc('0, 1, 1, 5'h0C);            chk("R7 control readback", 1, 32'h0C, 1);
    cyc('0, 1, 1, 5'h0E);            chk("R7 start dma", 0, 32'h00, 0);
    pulse(0);                        chk("R7 dma rx", 0, 32'h02, 0);
    pulse(1);                        chk("R7 dma tx", 0, 32'h04, 0);
    pulse(3);                        chk("R7 dma nack", 0, 32'h09, 1);
    cyc('0, 1, 0, 5'h0F);            chk("R11 status ro", 0, 32'h09, 1);
    cyc('0, 1, 1, 5'h1C);            chk("R11 ctrl strobes read 0", 1, 32'h0C, 1);
    chk("R11 status unchanged", 0, 32'h09, 1);
    cyc('0, 1, 1, 5'h00);            chk("R10 irq off", 0, 32'h09, 0);
    cyc('0, 1, 1, 5'h08);
    cyc(7'h01, 1, 1, 5'h0A);         chk("R8 event beats command", 0, 32'h03, 1);
    cyc('0, 1, 1, 5'h0A);            chk("R8 start again", 0, 32'h02, 0);
    repeat (2) @(negedge clk);
    model_on = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule